// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Signed Overflow Flag

This block is the combinational integer execute unit of a load-store RISC datapath. It takes two 32-bit operands and a 4-bit operation code and returns a 32-bit result, a flag that is high when the result is all zeros, and a flag that reports two's-complement overflow. The zero flag is what the branch logic uses for equal and not-equal decisions, normally after a subtract.

The unit performs bitwise AND, OR, XOR and NOR, addition and subtraction, and less-than comparison. Addition, subtraction and comparison each come in two forms, signed and unsigned. Only signed addition and signed subtraction can raise the overflow flag. The flag is only a flag: any trap or exception is handled by the surrounding pipeline.

A 16-bit immediate can replace the second operand. An extender inside the block widens the immediate. It sign-extends the immediate for the arithmetic and comparison codes and zero-extends it for the bitwise codes, so instruction decode passes the raw immediate field.

Top module: `int_alu`

## Requirements
- R1: Codes 0000, 0001, 0010 and 0011 give the bitwise AND, OR, XOR and NOR of A and the second operand.
- R2: Codes 0100 (signed add) and 0101 (unsigned add) give A plus the second operand, modulo 2^32.
- R3: Codes 0110 (signed subtract) and 0111 (unsigned subtract) give A minus the second operand, modulo 2^32.
- R4: On signed add, ovf_o is high exactly when both operands are non-negative and the result is negative, or both are negative and the result is non-negative. When the operand signs differ, ovf_o is never high.
- R5: On signed subtract, ovf_o is high exactly when A is non-negative, the second operand is negative and the result is negative, or A is negative, the second operand is non-negative and the result is non-negative. When the operand signs match, ovf_o is never high.
- R6: For every code other than 0100 and 0110, ovf_o is low. This includes the unsigned add and subtract forms when they wrap.
- R7: Code 1000 returns 1 in bit 0 when A is less than the second operand as signed numbers, and 0 otherwise. Bits 31..1 are 0. The answer is correct even when the internal difference overflows.
- R8: Code 1001 does the same comparison with both operands taken as unsigned numbers. Bits 31..1 are 0.
- R9: zero_o is high exactly when all 32 bits of result_o are 0, for every code.
- R10: When use_imm_i is 1, the second operand is imm_i widened to 32 bits and b_i is ignored. The widening is zero extension for codes 0000 to 0011 and sign extension (bit 15 copied upward) for codes 0100 to 1001.
- R11: Codes 1010 to 1111 give result 0, zero_o high and ovf_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand from the register path |
| imm_i | input | 16 | Raw immediate field |
| use_imm_i | input | 1 | Selects the widened immediate as the second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The adder is exercised at the signed boundaries:
- The largest positive value plus one, the most negative value plus itself, and opposite-sign sums separate a correct sign rule from one that reacts to the carry alone.
- The same boundary operand pairs under the unsigned codes show that the flag stays low when the sum wraps.

The comparisons use pairs whose internal difference overflows, such as the most negative value against one. These pairs separate a correct signed compare from one that reads only the sign bit, and an unsigned compare from a signed one. The immediate tests use an immediate with bit 15 set under an add code and under a bitwise code, which tells sign extension from zero extension.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    parameter int unsigned ALU_DW = 32;
    parameter int unsigned ALU_IW = 16;
    parameter int unsigned ALU_OPW = 4;

    typedef enum logic [ALU_OPW-1:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_XOR  = 4'b0010,
        OP_NOR  = 4'b0011,
        OP_ADD  = 4'b0100,
        OP_ADDU = 4'b0101,
        OP_SUB  = 4'b0110,
        OP_SUBU = 4'b0111,
        OP_SLT  = 4'b1000,
        OP_SLTU = 4'b1001
    } alu_op_e;

    // bitwise function select for the logic unit
    typedef enum logic [1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_XOR = 2'b10,
        LF_NOR = 2'b11
    } logic_fn_e;

endpackage

// File: rtl/int_alu_imm_ext.sv
module int_alu_imm_ext #(
    parameter int unsigned DW = 32,
    parameter int unsigned IW = 16
) (
    input  logic [IW-1:0] imm_i,
    input  logic          zext_i,
    output logic [DW-1:0] ext_o
);
    localparam int unsigned PADW = DW - IW;

    logic fill_d;

    always_comb begin
        fill_d = zext_i ? 1'b0 : imm_i[IW-1];
    end

    generate
        if (PADW > 0) begin : g_pad
            assign ext_o = {{PADW{fill_d}}, imm_i};
        end else begin : g_nopad
            logic unused_fill;
            assign unused_fill = fill_d;
            assign ext_o = imm_i[DW-1:0];
        end
    endgenerate

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int unsigned DW = 32,
    parameter int unsigned GW = 4
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o
);
    localparam int unsigned NG = DW / GW;

    logic [NG-1:0] grp_gen;
    logic [NG-1:0] grp_prop;
    logic [NG:0]   grp_cin;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            logic [GW-1:0] bit_g;
            logic [GW-1:0] bit_p;
            logic [GW-1:0] s_loc;
            logic          gen_d;
            logic          prop_d;

            assign bit_g = a_i[g*GW +: GW] & b_i[g*GW +: GW];
            assign bit_p = a_i[g*GW +: GW] ^ b_i[g*GW +: GW];

            // group generate / propagate, independent of carry-in
            always_comb begin
                gen_d  = 1'b0;
                prop_d = 1'b1;
                for (int i = 0; i < int'(GW); i++) begin
                    gen_d  = bit_g[i] | (bit_p[i] & gen_d);
                    prop_d = prop_d & bit_p[i];
                end
            end

            // sum bits inside the group from the group carry-in
            always_comb begin
                logic c;
                c = grp_cin[g];
                for (int i = 0; i < int'(GW); i++) begin
                    s_loc[i] = bit_p[i] ^ c;
                    c        = bit_g[i] | (bit_p[i] & c);
                end
            end

            assign grp_gen[g]        = gen_d;
            assign grp_prop[g]       = prop_d;
            assign sum_o[g*GW +: GW] = s_loc;
        end
    endgenerate

    // carry between groups
    always_comb begin
        logic c;
        c          = cin_i;
        grp_cin[0] = c;
        for (int g = 0; g < int'(NG); g++) begin
            c            = grp_gen[g] | (grp_prop[g] & c);
            grp_cin[g+1] = c;
        end
    end

    assign cout_o = grp_cin[NG];

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic_fn_e     fn_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        unique case (fn_i)
            LF_AND:  y_o = a_i & b_i;
            LF_OR:   y_o = a_i | b_i;
            LF_XOR:  y_o = a_i ^ b_i;
            LF_NOR:  y_o = ~(a_i | b_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned DW  = ALU_DW,
    parameter int unsigned IW  = ALU_IW,
    parameter int unsigned GW  = 4
) (
    input  logic [DW-1:0]      a_i,
    input  logic [DW-1:0]      b_i,
    input  logic [IW-1:0]      imm_i,
    input  logic               use_imm_i,
    input  logic [ALU_OPW-1:0] op_i,
    output logic [DW-1:0]      result_o,
    output logic               zero_o,
    output logic               ovf_o
);
    localparam int unsigned MSB = DW - 1;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          zero;
        logic          ovf;
    } alu_out_t;

    typedef struct packed {
        logic is_logic;
        logic is_sub;
        logic ovf_en;
    } alu_dec_t;

    alu_dec_t      dec_d;
    alu_out_t      alu_d;
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] b_opnd;
    logic [DW-1:0] b_add;
    logic [DW-1:0] sum;
    logic          cout;
    logic [DW-1:0] logic_y;
    logic          sgn_ovf;
    logic          lt_signed;
    logic          lt_unsigned;

    // operation decode
    always_comb begin
        dec_d.is_logic = (op_i[3:2] == 2'b00);
        dec_d.is_sub   = (op_i == OP_SUB)  || (op_i == OP_SUBU) ||
                         (op_i == OP_SLT)  || (op_i == OP_SLTU);
        dec_d.ovf_en   = (op_i == OP_ADD)  || (op_i == OP_SUB);
    end

    int_alu_imm_ext #(
        .DW(DW),
        .IW(IW)
    ) u_ext (
        .imm_i (imm_i),
        .zext_i(dec_d.is_logic),
        .ext_o (imm_ext)
    );

    assign b_opnd = use_imm_i ? imm_ext : b_i;
    assign b_add  = dec_d.is_sub ? ~b_opnd : b_opnd;

    int_alu_adder #(
        .DW(DW),
        .GW(GW)
    ) u_add (
        .a_i   (a_i),
        .b_i   (b_add),
        .cin_i (dec_d.is_sub),
        .sum_o (sum),
        .cout_o(cout)
    );

    int_alu_logic #(
        .DW(DW)
    ) u_log (
        .a_i (a_i),
        .b_i (b_opnd),
        .fn_i(logic_fn_e'(op_i[1:0])),
        .y_o (logic_y)
    );

    // sign rule on the adder inputs: like signs in, different sign out
    always_comb begin
        sgn_ovf     = (a_i[MSB] == b_add[MSB]) && (sum[MSB] != a_i[MSB]);
        lt_signed   = sum[MSB] ^ sgn_ovf;
        lt_unsigned = ~cout;
    end

    always_comb begin
        alu_d = '0;
        case (op_i)
            OP_AND, OP_OR, OP_XOR, OP_NOR:     alu_d.res = logic_y;
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:  alu_d.res = sum;
            OP_SLT:  alu_d.res = {{(DW-1){1'b0}}, lt_signed};
            OP_SLTU: alu_d.res = {{(DW-1){1'b0}}, lt_unsigned};
            default: alu_d.res = '0;
        endcase
        alu_d.ovf  = dec_d.ovf_en & sgn_ovf;
        alu_d.zero = ~|alu_d.res;
    end

    assign result_o = alu_d.res;
    assign zero_o   = alu_d.zero;
    assign ovf_o    = alu_d.ovf;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic [DW-1:0]      a_i,
    input logic [DW-1:0]      b_eff,
    input logic [ALU_OPW-1:0] op_i,
    input logic [DW-1:0]      result_o,
    input logic               zero_o,
    input logic               ovf_o
);
    localparam int unsigned MSB = DW - 1;

    logic [DW:0] wide_sum;
    assign wide_sum = {a_i[MSB], a_i} + {b_eff[MSB], b_eff};

    always_comb begin
        if (op_i == OP_ADD || op_i == OP_ADDU) begin
            a_r2_add_value: assert (result_o == a_i + b_eff)
                else $error("R2 sum mismatch");
        end
        if (op_i == OP_ADD) begin
            a_r4_add_ovf: assert (ovf_o == (wide_sum[DW] != wide_sum[MSB]))
                else $error("R4 add overflow mismatch");
        end
        if (op_i == OP_SUB) begin
            a_r5_sub_ovf: assert (ovf_o ==
                ((!a_i[MSB] && b_eff[MSB] && result_o[MSB]) ||
                 (a_i[MSB] && !b_eff[MSB] && !result_o[MSB])))
                else $error("R5 sub overflow mismatch");
        end
        if (op_i != OP_ADD && op_i != OP_SUB) begin
            a_r6_no_overflow: assert (!ovf_o)
                else $error("R6 overflow on non-signed op");
        end
        if (op_i == OP_SLT || op_i == OP_SLTU) begin
            a_r7_slt_upper_zero: assert (result_o[MSB:1] == '0)
                else $error("R7 compare upper bits set");
        end
        if (op_i == OP_SLTU) begin
            a_r8_sltu_value: assert (result_o[0] == (a_i < b_eff))
                else $error("R8 unsigned compare mismatch");
        end
        if (op_i[3:1] == 3'b101 || op_i[3:2] == 2'b11) begin
            a_r11_undefined: assert (result_o == '0 && zero_o && !ovf_o)
                else $error("R11 undefined code output");
        end
    end

endmodule

bind int_alu int_alu_chk #(.DW(DW)) u_chk (
    .a_i     (a_i),
    .b_eff   (b_opnd),
    .op_i    (op_i),
    .result_o(result_o),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    int_alu dut (
        .a_i      (a),
        .b_i      (b),
        .imm_i    (imm),
        .use_imm_i(use_imm),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero),
        .ovf_o    (ovf)
    );

    // reference: wide signed arithmetic, independent of the adder
    function automatic logic [33:0] ref_alu(input logic [31:0] ra, input logic [31:0] rb,
                                            input logic [3:0] rop, input logic [15:0] rimm,
                                            input logic ruse);
        logic [31:0] bb;
        logic [31:0] res;
        logic        of;
        longint      sa;
        longint      sb;
        longint      r;
        bb = ruse ? ((rop < 4'd4) ? {16'h0, rimm} : {{16{rimm[15]}}, rimm}) : rb;
        sa = longint'($signed(ra));
        sb = longint'($signed(bb));
        of = 1'b0;
        res = '0;
        case (rop)
            4'd0: res = ra & bb;
            4'd1: res = ra | bb;
            4'd2: res = ra ^ bb;
            4'd3: res = ~(ra | bb);
            4'd4, 4'd5: begin
                res = ra + bb;
                r = sa + sb;
                of = (rop == 4'd4) && (r > 64'sd2147483647 || r < -64'sd2147483648);
            end
            4'd6, 4'd7: begin
                res = ra - bb;
                r = sa - sb;
                of = (rop == 4'd6) && (r > 64'sd2147483647 || r < -64'sd2147483648);
            end
            4'd8: res = {31'b0, sa < sb};
            4'd9: res = {31'b0, ra < bb};
            default: res = '0;
        endcase
        return {of, (res == 32'd0), res};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic run(input string req, input logic [31:0] ra, input logic [31:0] rb,
                       input logic [3:0] rop, input logic [15:0] rimm, input logic ruse);
        logic [33:0] e;
        @(negedge clk);
        a = ra; b = rb; op = rop; imm = rimm; use_imm = ruse;
        #2;
        e = ref_alu(ra, rb, rop, rimm, ruse);
        check(req, "result", result, e[31:0]);
        check(req, "zero", {31'b0, zero}, {31'b0, e[32]});
        check(req, "ovf", {31'b0, ovf}, {31'b0, e[33]});
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        #2;
        check("R1", "idle and result", result, 32'h0);
        check("R9", "idle zero", {31'b0, zero}, 32'd1);
        check("R6", "idle ovf", {31'b0, ovf}, 32'd0);
    endtask

    task automatic t_logic_r1();
        run("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd0, 16'h0, 1'b0);
        run("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd1, 16'h0, 1'b0);
        run("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd2, 16'h0, 1'b0);
        run("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd3, 16'h0, 1'b0);
    endtask

    task automatic t_add_r2_r4();
        run("R2", 32'h1234_5678, 32'h1111_1111, 4'd5, 16'h0, 1'b0);
        run("R4", 32'h7FFF_FFFF, 32'h0000_0001, 4'd4, 16'h0, 1'b0);
        run("R4", 32'h8000_0000, 32'h8000_0000, 4'd4, 16'h0, 1'b0);
        run("R4", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd4, 16'h0, 1'b0);
        run("R4", 32'h8000_0000, 32'h7FFF_FFFF, 4'd4, 16'h0, 1'b0);
        run("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4, 16'h0, 1'b0);
    endtask

    task automatic t_sub_r3_r5();
        run("R3", 32'h0000_0005, 32'h0000_0009, 4'd7, 16'h0, 1'b0);
        run("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd6, 16'h0, 1'b0);
        run("R5", 32'h8000_0000, 32'h0000_0001, 4'd6, 16'h0, 1'b0);
        run("R5", 32'h8000_0000, 32'h8000_0000, 4'd6, 16'h0, 1'b0);
        run("R5", 32'h0000_0003, 32'h7FFF_FFFF, 4'd6, 16'h0, 1'b0);
    endtask

    task automatic t_unsigned_r6();
        run("R6", 32'h7FFF_FFFF, 32'h0000_0001, 4'd5, 16'h0, 1'b0);
        run("R6", 32'h8000_0000, 32'h8000_0000, 4'd5, 16'h0, 1'b0);
        run("R6", 32'h8000_0000, 32'h0000_0001, 4'd7, 16'h0, 1'b0);
        run("R6", 32'h8000_0000, 32'h0000_0001, 4'd8, 16'h0, 1'b0);
    endtask

    task automatic t_slt_r7();
        run("R7", 32'h8000_0000, 32'h0000_0001, 4'd8, 16'h0, 1'b0);
        run("R7", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd8, 16'h0, 1'b0);
        run("R7", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'd8, 16'h0, 1'b0);
        run("R7", 32'h0000_0004, 32'h0000_0004, 4'd8, 16'h0, 1'b0);
    endtask

    task automatic t_sltu_r8();
        run("R8", 32'h0000_0001, 32'hFFFF_FFFF, 4'd9, 16'h0, 1'b0);
        run("R8", 32'h8000_0000, 32'h0000_0001, 4'd9, 16'h0, 1'b0);
        run("R8", 32'h0000_0007, 32'h0000_0007, 4'd9, 16'h0, 1'b0);
    endtask

    task automatic t_zero_r9();
        run("R9", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd6, 16'h0, 1'b0);
        run("R9", 32'hAAAA_0000, 32'h5555_FFFF, 4'd0, 16'h0, 1'b0);
        run("R9", 32'h0000_0000, 32'h0000_0001, 4'd4, 16'h0, 1'b0);
    endtask

    task automatic t_imm_r10();
        run("R10", 32'h0000_0010, 32'h1234_5678, 4'd4, 16'hFFFF, 1'b1);
        run("R10", 32'h1200_0000, 32'hFFFF_FFFF, 4'd1, 16'hFFFF, 1'b1);
        run("R10", 32'h8765_4321, 32'h0000_0000, 4'd0, 16'h8001, 1'b1);
        run("R10", 32'h0000_0001, 32'h0000_0000, 4'd9, 16'h8000, 1'b1);
        run("R10", 32'hFFFF_0000, 32'h0000_0000, 4'd8, 16'h8000, 1'b1);
    endtask

    task automatic t_undef_r11();
        for (int k = 10; k < 16; k++) begin
            run("R11", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'(k), 16'h0, 1'b0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_logic_r1();
        t_add_r2_r4();
        t_sub_r3_r5();
        t_unsigned_r6();
        t_slt_r7();
        t_sltu_r8();
        t_zero_r9();
        t_imm_r10();
        t_undef_r11();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule